// File: doc/BRIEF.md
# Segment Translation and Miss Syndrome Generator

This block handles the paged half of address translation for 32-bit effective addresses that did not hit a block translation. It holds sixteen segment words. For each request it picks one of them with the top four address bits and works out the protection key, the page-table hash and the tag word that a TLB entry is compared against. Segment-level outcomes are resolved at once, with no TLB round trip: a fetch from a no-execute segment, and every access to a direct-store segment.

Paged requests are handed to an external TLB as a lookup pulse that carries the tag word and the key. When the TLB reports hit, miss or protection denial, the block registers a complete syndrome. On a miss this includes the miss address, a compare word with its valid bit set, and the primary and secondary page-table-group addresses, so that a software refill handler can start loading the TLB straight away. On a denial it produces the data-fault status word or the fetch error code.

Top module: `sxl_unit`

## Requirements
- R1: The segment word used by a request is entry `req_ea[31:28]`. A write through `seg_we`/`seg_widx`/`seg_wdata` is seen by requests from the next cycle on. All entries reset to zero.
- R2: The key is segment bit 29 when `req_user`=1 and segment bit 30 when `req_user`=0. It is returned on `lk_key` and used by every outcome that depends on the key.
- R3: A paged request (segment bit 31 clear, and not a fetch from a segment with bit 28 set) raises `lk_valid` for exactly one cycle, one cycle after the request. `lk_ptem` = (VSID<<7) | (page>>10), where VSID = segment bits 23:0 and page = `req_ea[27:12]`. `lk_ptem` and `lk_key` hold until the next paged request.
- R4: A fetch (`req_acc`=0) from a paged segment with bit 28 set gives cause 7 with `res_err`=0x10000000, one cycle after the request, and no lookup.
- R5: A TLB miss (`tlb_hit`=0) gives `res_miss_addr`=EA and `res_cmp`=0x80000000|PTEM. `res_err` = key<<19, plus bit 18 for a fetch (cause 3) or bit 16 for a store (cause 5). A load miss is cause 4.
- R6: On a miss, with hash = VSID XOR page, `res_hash1` = `htab_base` + ((hash & {`htab_mask`,10'h3FF})<<6) and `res_hash2` uses the 24-bit complement of the hash. Base and mask are sampled in the cycle of the TLB response.
- R7: A denial (`tlb_hit`=1, `tlb_deny`=1) on a load or store gives cause 8, `res_dar`=EA, and `res_dsisr`=0x0A000000 for a store or 0x08000000 for a load. On a fetch it gives cause 6 with `res_err`=0x08000000.
- R8: In a direct-store segment (bit 31 set), a fetch gives cause 7 with `res_err`=0x10000000. An integer access (`req_cls`=0) passes untranslated (cause 2) unless the key is 1 on a load or 0 on a store, which gives cause 8 with the same status words as R7.
- R9: In a direct-store segment, a float access (`req_cls`=1) gives cause 10 with `res_dar`=EA. A reservation access (2) gives cause 9 with `res_dsisr` 0x06000000 for a store or 0x04000000 for a load. An external-control access (4) gives cause 9 with 0x06100000 or 0x04100000. A cache-control access (3) gives cause 2. Loads use `req_acc`=1 and stores use `req_acc`=2.
- R10: `res_valid` pulses one cycle after `tlb_valid` while a lookup is pending, and one cycle after a request that needs no lookup. A `tlb_valid` with nothing pending produces no result.
- R11: After reset every output is zero.
- R12: A hit with no denial gives cause 1, and all syndrome fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment word write enable |
| seg_widx | input | 4 | Segment entry to write |
| seg_wdata | input | 32 | Segment word value |
| req_valid | input | 1 | Translation request strobe |
| req_ea | input | 32 | Effective address |
| req_acc | input | 2 | 0 fetch, 1 load, 2 store |
| req_cls | input | 3 | Data class: 0 int, 1 float, 2 reservation, 3 cache, 4 external |
| req_user | input | 1 | 1 for user privilege |
| htab_base | input | 32 | Page table base address |
| htab_mask | input | 9 | Page table size mask |
| tlb_valid | input | 1 | TLB response strobe |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_deny | input | 1 | Matching entry forbids the access |
| lk_valid | output | 1 | Lookup request pulse |
| lk_ptem | output | 32 | Tag word for the TLB compare |
| lk_key | output | 1 | Protection key for the lookup |
| res_valid | output | 1 | Result pulse |
| res_cause | output | 4 | Outcome code |
| res_err | output | 32 | Error code word |
| res_miss_addr | output | 32 | Miss address |
| res_cmp | output | 32 | Valid-tagged compare word |
| res_hash1 | output | 32 | Primary group address |
| res_hash2 | output | 32 | Secondary group address |
| res_dar | output | 32 | Data fault address |
| res_dsisr | output | 32 | Data fault status word |

## Verification
A request that needs no lookup produces its result one clock edge after the edge that samples it. A paged request produces its lookup pulse at that same edge, and its result comes one edge after the edge that samples the TLB response. The reference model advances on each rising edge, on the same inputs the design samples, and every output is compared with it at the following falling edge. Waits between a lookup and its response of zero to several cycles, and stray responses with nothing pending, check that the result timing follows the response and not the request.

// File: rtl/sxl_pkg.sv
package sxl_pkg;

  localparam int EA_W    = 32;
  localparam int VSID_W  = 24;
  localparam int PG_W    = 16;
  localparam int HMASK_W = 9;
  localparam int GRP_SH  = 6;

  localparam logic [31:0] CODE_NOEXEC   = 32'h1000_0000;
  localparam logic [31:0] CODE_PROT     = 32'h0800_0000;
  localparam logic [31:0] STAT_ST_PROT  = 32'h0A00_0000;
  localparam logic [31:0] STAT_LD_PROT  = 32'h0800_0000;
  localparam logic [31:0] STAT_ST_RESV  = 32'h0600_0000;
  localparam logic [31:0] STAT_LD_RESV  = 32'h0400_0000;
  localparam logic [31:0] STAT_ST_EXT   = 32'h0610_0000;
  localparam logic [31:0] STAT_LD_EXT   = 32'h0410_0000;
  localparam logic [31:0] CMP_VALID     = 32'h8000_0000;
  localparam logic [31:0] ERR_FETCH_BIT = 32'h0004_0000;
  localparam logic [31:0] ERR_STORE_BIT = 32'h0001_0000;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [2:0] {CLS_INT = 3'd0, CLS_FLOAT = 3'd1, CLS_RESV = 3'd2,
                            CLS_CACHE = 3'd3, CLS_EXT = 3'd4} cls_e;
  typedef enum logic [3:0] {
    C_NONE = 4'd0, C_XLATE_OK = 4'd1, C_DS_PASS = 4'd2, C_ITLB_MISS = 4'd3,
    C_DLD_MISS = 4'd4, C_DST_MISS = 4'd5, C_ISI_PROT = 4'd6, C_ISI_NOEXEC = 4'd7,
    C_DSI_PROT = 4'd8, C_DSI_DS = 4'd9, C_ALIGN = 4'd10
  } cause_e;

  typedef struct packed {
    cause_e      cause;
    logic [31:0] err;
    logic [31:0] miss;
    logic [31:0] cmp;
    logic [31:0] h1;
    logic [31:0] h2;
    logic [31:0] dar;
    logic [31:0] dsisr;
  } res_t;

  function automatic logic seg_key(input logic [31:0] sr, input logic user);
    return user ? sr[29] : sr[30];
  endfunction

  function automatic logic [PG_W-1:0] page_of(input logic [EA_W-1:0] ea);
    return ea[27:12];
  endfunction

  function automatic logic [VSID_W-1:0] hash_of(input logic [VSID_W-1:0] vsid,
                                                input logic [PG_W-1:0] pg);
    return vsid ^ {{(VSID_W-PG_W){1'b0}}, pg};
  endfunction

  function automatic logic [31:0] ptem_of(input logic [VSID_W-1:0] vsid,
                                          input logic [PG_W-1:0] pg);
    return {1'b0, vsid, 1'b0, pg[15:10]};
  endfunction

  function automatic logic [31:0] group_addr(input logic [31:0] base,
                                             input logic [HMASK_W-1:0] mask,
                                             input logic [VSID_W-1:0] h);
    logic [HMASK_W+9:0] sel;
    sel = h[HMASK_W+9:0] & {mask, 10'h3FF};
    return base + {{(32-HMASK_W-10-GRP_SH){1'b0}}, sel, {GRP_SH{1'b0}}};
  endfunction

endpackage

// File: rtl/sxl_segfile.sv
module sxl_segfile #(
  parameter int NSEG = 16,
  parameter int W    = 32,
  localparam int IW  = $clog2(NSEG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ridx,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] regs [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (we && widx == IW'(g)) regs[g] <= wdata;
    end
  end

  assign rdata = regs[ridx];
endmodule

// File: rtl/sxl_classify.sv
module sxl_classify
  import sxl_pkg::*;
(
  input  logic [31:0] ea,
  input  logic [1:0]  acc,
  input  logic [2:0]  cls,
  input  logic        user,
  input  logic [31:0] sr,
  output logic        key,
  output logic [VSID_W-1:0] hash,
  output logic [31:0] ptem,
  output logic        need_tlb,
  output res_t        imm
);
  logic [VSID_W-1:0] vsid;
  logic [PG_W-1:0]   pg;
  logic              is_fetch, is_store, ds_ok;
  logic              sxl_unused_rsv;

  assign sxl_unused_rsv = ^sr[27:24];
  assign vsid     = sr[VSID_W-1:0];
  assign pg       = page_of(ea);
  assign key      = seg_key(sr, user);
  assign hash     = hash_of(vsid, pg);
  assign ptem     = ptem_of(vsid, pg);
  assign is_fetch = (acc == ACC_FETCH);
  assign is_store = (acc == ACC_STORE);
  assign ds_ok    = (is_store || !key) && (!is_store || key);

  always_comb begin
    imm      = '0;
    need_tlb = 1'b0;
    if (!sr[31]) begin
      if (is_fetch && sr[28]) begin
        imm.cause = C_ISI_NOEXEC;
        imm.err   = CODE_NOEXEC;
      end else begin
        need_tlb = 1'b1;
      end
    end else if (is_fetch) begin
      imm.cause = C_ISI_NOEXEC;
      imm.err   = CODE_NOEXEC;
    end else begin
      unique case (cls)
        CLS_INT: begin
          if (ds_ok) begin
            imm.cause = C_DS_PASS;
          end else begin
            imm.cause = C_DSI_PROT;
            imm.dar   = ea;
            imm.dsisr = is_store ? STAT_ST_PROT : STAT_LD_PROT;
          end
        end
        CLS_CACHE: imm.cause = C_DS_PASS;
        CLS_FLOAT: begin
          imm.cause = C_ALIGN;
          imm.dar   = ea;
        end
        CLS_RESV: begin
          imm.cause = C_DSI_DS;
          imm.dar   = ea;
          imm.dsisr = is_store ? STAT_ST_RESV : STAT_LD_RESV;
        end
        default: begin
          imm.cause = C_DSI_DS;
          imm.dar   = ea;
          imm.dsisr = is_store ? STAT_ST_EXT : STAT_LD_EXT;
        end
      endcase
    end
  end
endmodule

// File: rtl/sxl_syndrome.sv
module sxl_syndrome
  import sxl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] ea,
  input  logic [1:0]  acc,
  input  logic        key,
  input  logic [VSID_W-1:0] hash,
  input  logic [31:0] ptem,
  input  logic        need_tlb,
  input  res_t        imm,
  input  logic [31:0] htab_base,
  input  logic [HMASK_W-1:0] htab_mask,
  input  logic        tlb_valid,
  input  logic        tlb_hit,
  input  logic        tlb_deny,
  output logic        pend,
  output logic        lk_valid,
  output logic [31:0] lk_ptem,
  output logic        lk_key,
  output logic        res_valid,
  output res_t        res
);
  logic [31:0]       c_ea;
  logic [1:0]        c_acc;
  logic [VSID_W-1:0] c_hash;
  logic              tlb_take;
  res_t              tlb_res;

  assign tlb_take = tlb_valid && pend;

  always_comb begin
    tlb_res = '0;
    if (!tlb_hit) begin
      tlb_res.miss = c_ea;
      tlb_res.cmp  = CMP_VALID | lk_ptem;
      tlb_res.h1   = group_addr(htab_base, htab_mask, c_hash);
      tlb_res.h2   = group_addr(htab_base, htab_mask, ~c_hash);
      tlb_res.err  = 32'(lk_key) << 19;
      if (c_acc == ACC_FETCH) begin
        tlb_res.cause = C_ITLB_MISS;
        tlb_res.err   = tlb_res.err | ERR_FETCH_BIT;
      end else if (c_acc == ACC_STORE) begin
        tlb_res.cause = C_DST_MISS;
        tlb_res.err   = tlb_res.err | ERR_STORE_BIT;
      end else begin
        tlb_res.cause = C_DLD_MISS;
      end
    end else if (tlb_deny) begin
      if (c_acc == ACC_FETCH) begin
        tlb_res.cause = C_ISI_PROT;
        tlb_res.err   = CODE_PROT;
      end else begin
        tlb_res.cause = C_DSI_PROT;
        tlb_res.dar   = c_ea;
        tlb_res.dsisr = (c_acc == ACC_STORE) ? STAT_ST_PROT : STAT_LD_PROT;
      end
    end else begin
      tlb_res.cause = C_XLATE_OK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      lk_valid  <= 1'b0;
      lk_ptem   <= '0;
      lk_key    <= 1'b0;
      res_valid <= 1'b0;
      res       <= '0;
      c_ea      <= '0;
      c_acc     <= '0;
      c_hash    <= '0;
    end else begin
      lk_valid  <= 1'b0;
      res_valid <= 1'b0;
      if (tlb_take) begin
        res_valid <= 1'b1;
        res       <= tlb_res;
        pend      <= 1'b0;
      end else if (req_valid && !need_tlb) begin
        res_valid <= 1'b1;
        res       <= imm;
      end
      if (req_valid && need_tlb) begin
        pend     <= 1'b1;
        lk_valid <= 1'b1;
        lk_ptem  <= ptem;
        lk_key   <= key;
        c_ea     <= ea;
        c_acc    <= acc;
        c_hash   <= hash;
      end
    end
  end
endmodule

// File: rtl/sxl_unit.sv
module sxl_unit
  import sxl_pkg::*;
#(
  parameter int NSEG = 16,
  localparam int SEG_W = $clog2(NSEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               seg_we,
  input  logic [SEG_W-1:0]   seg_widx,
  input  logic [31:0]        seg_wdata,
  input  logic               req_valid,
  input  logic [31:0]        req_ea,
  input  logic [1:0]         req_acc,
  input  logic [2:0]         req_cls,
  input  logic               req_user,
  input  logic [31:0]        htab_base,
  input  logic [HMASK_W-1:0] htab_mask,
  input  logic               tlb_valid,
  input  logic               tlb_hit,
  input  logic               tlb_deny,
  output logic               lk_valid,
  output logic [31:0]        lk_ptem,
  output logic               lk_key,
  output logic               res_valid,
  output logic [3:0]         res_cause,
  output logic [31:0]        res_err,
  output logic [31:0]        res_miss_addr,
  output logic [31:0]        res_cmp,
  output logic [31:0]        res_hash1,
  output logic [31:0]        res_hash2,
  output logic [31:0]        res_dar,
  output logic [31:0]        res_dsisr
);
  logic [31:0]       seg_word;
  logic              key_w;
  logic [VSID_W-1:0] hash_w;
  logic [31:0]       ptem_w;
  logic              need_tlb_w;
  logic              pend_w;
  res_t              imm_w;
  res_t              res_w;

  sxl_segfile #(.NSEG(NSEG), .W(32)) i_segs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seg_we),
    .widx  (seg_widx),
    .wdata (seg_wdata),
    .ridx  (req_ea[31 -: SEG_W]),
    .rdata (seg_word)
  );

  sxl_classify i_cls (
    .ea       (req_ea),
    .acc      (req_acc),
    .cls      (req_cls),
    .user     (req_user),
    .sr       (seg_word),
    .key      (key_w),
    .hash     (hash_w),
    .ptem     (ptem_w),
    .need_tlb (need_tlb_w),
    .imm      (imm_w)
  );

  sxl_syndrome i_syn (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .ea        (req_ea),
    .acc       (req_acc),
    .key       (key_w),
    .hash      (hash_w),
    .ptem      (ptem_w),
    .need_tlb  (need_tlb_w),
    .imm       (imm_w),
    .htab_base (htab_base),
    .htab_mask (htab_mask),
    .tlb_valid (tlb_valid),
    .tlb_hit   (tlb_hit),
    .tlb_deny  (tlb_deny),
    .pend      (pend_w),
    .lk_valid  (lk_valid),
    .lk_ptem   (lk_ptem),
    .lk_key    (lk_key),
    .res_valid (res_valid),
    .res       (res_w)
  );

  assign res_cause     = res_w.cause;
  assign res_err       = res_w.err;
  assign res_miss_addr = res_w.miss;
  assign res_cmp       = res_w.cmp;
  assign res_hash1     = res_w.h1;
  assign res_hash2     = res_w.h2;
  assign res_dar       = res_w.dar;
  assign res_dsisr     = res_w.dsisr;
endmodule

// File: rtl/sxl_unit_chk.sv
module sxl_unit_chk
  import sxl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        tlb_valid,
  input logic        pend_w,
  input logic        lk_valid,
  input logic        res_valid,
  input logic [3:0]  res_cause,
  input logic [31:0] res_err,
  input logic [31:0] res_cmp,
  input logic [31:0] res_hash1,
  input logic [31:0] res_hash2,
  input logic [31:0] res_dsisr
);
  // R10
  tlb_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cause == C_XLATE_OK |-> $past(tlb_valid && pend_w));

  // R5
  miss_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && (res_cause == C_ITLB_MISS || res_cause == C_DLD_MISS || res_cause == C_DST_MISS)
    |-> res_cmp[31] && res_hash1[5:0] == 6'd0 && res_hash2[5:0] == 6'd0);

  // R7
  dsi_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cause == C_DSI_PROT |-> res_dsisr == STAT_ST_PROT || res_dsisr == STAT_LD_PROT);

  // R4
  nx_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cause == C_ISI_NOEXEC |-> res_err == CODE_NOEXEC && $past(req_valid));

  // R3
  lk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> pend_w && $past(req_valid));

  // R3
  lk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> !lk_valid || $past(req_valid));

  // R12
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_cause == C_XLATE_OK |-> res_err == 32'd0 && res_cmp == 32'd0 && res_dsisr == 32'd0);

  // R11
  cause_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_cause != C_NONE);
endmodule

bind sxl_unit sxl_unit_chk i_sxl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .tlb_valid (tlb_valid),
  .pend_w    (pend_w),
  .lk_valid  (lk_valid),
  .res_valid (res_valid),
  .res_cause (res_cause),
  .res_err   (res_err),
  .res_cmp   (res_cmp),
  .res_hash1 (res_hash1),
  .res_hash2 (res_hash2),
  .res_dsisr (res_dsisr)
);

// File: tb/test_sxl_unit.sv
module test_sxl_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seg_we = 1'b0;
  logic [3:0] seg_widx = '0;
  logic [31:0] seg_wdata = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_ea = '0;
  logic [1:0] req_acc = '0;
  logic [2:0] req_cls = '0;
  logic req_user = 1'b0;
  logic [31:0] htab_base = 32'h00A0_0000;
  logic [8:0] htab_mask = 9'h003;
  logic tlb_valid = 1'b0, tlb_hit = 1'b0, tlb_deny = 1'b0;
  logic lk_valid, lk_key, res_valid;
  logic [31:0] lk_ptem;
  logic [3:0] res_cause;
  logic [31:0] res_err, res_miss_addr, res_cmp, res_hash1, res_hash2, res_dar, res_dsisr;

  always #10 clk = ~clk;

  sxl_unit i_sxl_unit (.*);

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [31:0] m_seg [16];
  bit m_pend;
  logic [31:0] m_ea;
  int m_acc, m_key, m_hash;
  logic e_lkv, e_lkkey, e_resv;
  logic [31:0] e_ptem, e_err, e_miss, e_cmp, e_h1, e_h2, e_dar, e_dsisr;
  int e_cause;

  function automatic logic [31:0] grp(int h);
    int sel;
    sel = h & (int'(htab_mask) * 1024 + 1023);
    return htab_base + 32'(sel * 64);
  endfunction

  task automatic m_clear_res();
    e_err = 0; e_miss = 0; e_cmp = 0; e_h1 = 0; e_h2 = 0; e_dar = 0; e_dsisr = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_seg[i]) m_seg[i] = 0;
      m_pend = 0; e_lkv = 0; e_lkkey = 0; e_resv = 0; e_ptem = 0; e_cause = 0;
      m_clear_res();
    end else begin
      bit took;
      e_lkv = 0; e_resv = 0; took = 0;
      if (tlb_valid && m_pend) begin
        took = 1; m_pend = 0; e_resv = 1; m_clear_res();
        if (!tlb_hit) begin
          e_miss = m_ea; e_cmp = 32'h8000_0000 + e_ptem;
          e_h1 = grp(m_hash); e_h2 = grp(m_hash ^ 24'hFF_FFFF);
          e_err = m_key * 32'h0008_0000;
          if (m_acc == 0) begin e_cause = 3; e_err += 32'h0004_0000; end
          else if (m_acc == 2) begin e_cause = 5; e_err += 32'h0001_0000; end
          else e_cause = 4;
        end else if (tlb_deny) begin
          if (m_acc == 0) begin e_cause = 6; e_err = 32'h0800_0000; end
          else begin e_cause = 8; e_dar = m_ea; e_dsisr = (m_acc == 2) ? 32'h0A00_0000 : 32'h0800_0000; end
        end else e_cause = 1;
      end
      if (req_valid) begin
        logic [31:0] s;
        int vs, pg, k;
        bit st;
        s = m_seg[req_ea / 32'h1000_0000];
        vs = int'(s % 32'h0100_0000);
        pg = int'((req_ea / 4096) % 65536);
        k = req_user ? int'(s[29]) : int'(s[30]);
        st = (req_acc == 2);
        if (!s[31] && !(req_acc == 0 && s[28])) begin
          m_pend = 1; e_lkv = 1; e_lkkey = k[0];
          e_ptem = 32'(vs * 128 + pg / 1024);
          m_ea = req_ea; m_acc = req_acc; m_key = k; m_hash = vs ^ pg;
        end else if (!took) begin
          e_resv = 1; m_clear_res();
          if (req_acc == 0) begin e_cause = 7; e_err = 32'h1000_0000; end
          else case (req_cls)
            0: if ((k == 1 && !st) || (k == 0 && st)) begin
                 e_cause = 8; e_dar = req_ea; e_dsisr = st ? 32'h0A00_0000 : 32'h0800_0000;
               end else e_cause = 2;
            1: begin e_cause = 10; e_dar = req_ea; end
            2: begin e_cause = 9; e_dar = req_ea; e_dsisr = st ? 32'h0600_0000 : 32'h0400_0000; end
            3: e_cause = 2;
            default: begin e_cause = 9; e_dar = req_ea; e_dsisr = st ? 32'h0610_0000 : 32'h0410_0000; end
          endcase
        end
      end
      if (seg_we) m_seg[seg_widx] = seg_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string cause_tag(int c);
    case (c)
      0: return "R11";
      1: return "R12";
      2: return "R8";
      3, 4, 5: return "R5";
      6, 8: return "R7";
      7: return "R4";
      default: return "R9";
    endcase
  endfunction

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 res_valid", 32'(res_valid), 32'(e_resv));
      chk("R3 lk_valid", 32'(lk_valid), 32'(e_lkv));
      chk("R1/R3 lk_ptem", lk_ptem, e_ptem);
      chk("R2 lk_key", 32'(lk_key), 32'(e_lkkey));
      chk({cause_tag(e_cause), " cause"}, 32'(res_cause), 32'(e_cause));
      chk({cause_tag(e_cause), " err"}, res_err, e_err);
      chk("R5 miss_addr", res_miss_addr, e_miss);
      chk("R5 cmp", res_cmp, e_cmp);
      chk("R6 hash1", res_hash1, e_h1);
      chk("R6 hash2", res_hash2, e_h2);
      chk({cause_tag(e_cause), " dar"}, res_dar, e_dar);
      chk({cause_tag(e_cause), " dsisr"}, res_dsisr, e_dsisr);
    end
  end

  task automatic wr_seg(int idx, logic [31:0] v);
    @(negedge clk); seg_we = 1; seg_widx = 4'(idx); seg_wdata = v;
    @(negedge clk); seg_we = 0;
  endtask

  task automatic do_req(logic [31:0] ea, int acc, int cls, bit user);
    @(negedge clk);
    req_valid = 1; req_ea = ea; req_acc = 2'(acc); req_cls = 3'(cls); req_user = user;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic do_tlb(bit hit, bit deny, int dly);
    repeat (dly) @(negedge clk);
    tlb_valid = 1; tlb_hit = hit; tlb_deny = deny;
    @(negedge clk); tlb_valid = 0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    chk("R11 lk_valid", 32'(lk_valid), 0);
    chk("R11 res_valid", 32'(res_valid), 0);
    chk("R11 cause", 32'(res_cause), 0);
    chk("R11 hash1", res_hash1, 0);
    chk("R11 lk_ptem", lk_ptem, 0);
    rst_n = 1;
    wr_seg(0, 32'h0012_3456);
    wr_seg(1, 32'h60AB_CDEF);
    wr_seg(2, 32'h1000_0055);
    wr_seg(3, 32'h8000_0000);
    wr_seg(4, 32'hC000_0000);
    wr_seg(5, 32'h20FF_FFFF);
    // R5 misses and R6 groups
    do_req(32'h0ABC_D123, 1, 0, 0); do_tlb(0, 0, 0);
    do_req(32'h1FFF_F000, 2, 0, 1); do_tlb(0, 0, 2);
    do_req(32'h5000_1000, 0, 0, 1); do_tlb(0, 0, 1);
    // R12 hit, R7 denials
    do_req(32'h1234_5678, 1, 0, 0); do_tlb(1, 0, 0);
    do_req(32'h1234_5678, 2, 0, 0); do_tlb(1, 1, 0);
    do_req(32'h0234_5678, 1, 0, 0); do_tlb(1, 1, 3);
    do_req(32'h0234_5678, 0, 0, 0); do_tlb(1, 1, 0);
    // R4 no-execute fetch; load from same segment is paged
    do_req(32'h2000_4000, 0, 0, 0);
    do_req(32'h2000_4000, 1, 0, 0); do_tlb(0, 0, 0);
    // R10 stray response with nothing pending
    do_tlb(0, 0, 1);
    // R8 direct-store integer and fetch
    do_req(32'h3000_0010, 1, 0, 0);
    do_req(32'h3000_0010, 2, 0, 0);
    do_req(32'h4000_0020, 1, 0, 0);
    do_req(32'h4000_0020, 2, 0, 0);
    do_req(32'h4000_0020, 0, 0, 0);
    // R9 other direct-store classes
    for (int c = 1; c < 5; c++) begin
      do_req(32'h3000_0100, 1, c, 0);
      do_req(32'h4000_0200, 2, c, 1);
    end
    // R1 rewrite of an entry seen next request
    wr_seg(0, 32'h40FE_DCBA);
    do_req(32'h0000_3000, 1, 0, 0); do_tlb(0, 0, 0);
    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(0, 5) == 0) wr_seg($urandom_range(0, 15), $urandom);
      if ($urandom_range(0, 7) == 0) begin
        htab_base = $urandom & 32'hFFFF_0000; htab_mask = 9'($urandom);
      end
      do_req($urandom, $urandom_range(0, 2), $urandom_range(0, 4), 1'($urandom));
      if (m_pend) do_tlb(1'($urandom), 1'($urandom), $urandom_range(0, 3));
      else if ($urandom_range(0, 3) == 0) do_tlb(1'($urandom), 1'($urandom), 0);
    end
    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule